// File: doc/BRIEF.md
# Addressable Latch with Demultiplexer Mode

The block is an eight-location, one-bit-per-location storage register in which a serial data bit is steered into the location chosen by a three-bit address. It works as a clocked register model of an addressable latch. Two active-low controls, an enable and a common clear, are sampled on every rising clock edge. Together they pick one of four modes: addressed write, hold, one-hot demultiplex, or clear.

The outputs are registered, so the result of a sampled mode appears one cycle later. A monitor tracks the address sampled on each cycle. It raises a one-cycle flag when the address moves by two or more bits outside hold mode. Such a change would risk a transient wrong selection in a real latch.

Top module: `addr_latch`

## Requirements
- R1: The asynchronous active-low reset clears all outputs `q_o` to 0 and drives `addr_viol_o` low. The stored previous address becomes 0.
- R2: In write mode, encoded as `mr_ni`=1 and `le_ni`=0, the location selected by `addr_i` takes `data_i` after the sampling edge. Every other location keeps its value.
- R3: In hold mode, encoded as `mr_ni`=1 and `le_ni`=1, all outputs stay unchanged whatever `data_i` and `addr_i` are.
- R4: In demultiplex mode, encoded as `mr_ni`=0 and `le_ni`=0, the addressed output takes `data_i` and all other outputs go to 0.
- R5: In clear mode, encoded as `mr_ni`=0 and `le_ni`=1, all outputs go to 0 whatever `data_i` and `addr_i` are.
- R6: Address value k, read as an unsigned binary number, selects bit k of `q_o`.
- R7: `addr_viol_o` is high in the cycle after a sampling edge under these conditions: the mode is not hold, and `addr_i` differs in two or more bits from the address sampled at the previous edge. The previous address is tracked on every edge, including edges in hold mode.
- R8: `addr_viol_o` is low after any edge sampled in hold mode, and after any edge where the address changed by at most one bit.
- R9: A move from demultiplex or clear mode into hold keeps the last driven outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial data bit |
| addr_i | input | 3 | Location select |
| le_ni | input | 1 | Enable, active low |
| mr_ni | input | 1 | Common clear, active low |
| q_o | output | 8 | Stored / demultiplexed outputs |
| addr_viol_o | output | 1 | Multi-bit address change flag |

## Verification
A vector sequence moves through every mode with data 0 and 1. Some writes land on a set bit and others on a clear bit, which separates a write from a hold and from a demultiplex that wipes neighbours. Address steps of zero, one, two and three bits are used in write, demultiplex, clear and hold modes, which shows whether the flag depends on the mode or on the bit distance. A walk of all eight addresses in demultiplex mode confirms the bit mapping, and a mid-run reset confirms the clearing.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } lat_mode_e;
endpackage

// File: rtl/lat_mode_dec.sv
module lat_mode_dec
  import addr_latch_pkg::*;
(
  input  logic      le_ni,
  input  logic      mr_ni,
  output lat_mode_e mode_o
);
  always_comb begin
    unique case ({mr_ni, le_ni})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/lat_store.sv
module lat_store
  import addr_latch_pkg::*;
#(
  parameter int unsigned NLOC = 8,
  localparam int unsigned AW = $clog2(NLOC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  lat_mode_e       mode_i,
  input  logic            data_i,
  input  logic [AW-1:0]   addr_i,
  output logic [NLOC-1:0] q_o
);
  for (genvar i = 0; i < NLOC; i++) begin : g_loc
    logic sel;
    assign sel = (addr_i == AW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else begin
        unique case (mode_i)
          MODE_WRITE: if (sel) q_o[i] <= data_i;
          MODE_DEMUX: q_o[i] <= sel & data_i;
          MODE_CLEAR: q_o[i] <= 1'b0;
          default:    q_o[i] <= q_o[i];
        endcase
      end
    end
  end

  a_r3_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> $stable(q_o));
  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CLEAR) |=> (q_o == '0));
  a_r4_demux_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DEMUX) |=> $onehot0(q_o));
endmodule

// File: rtl/addr_watch.sv
module addr_watch
  import addr_latch_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lat_mode_e     mode_i,
  input  logic [AW-1:0] addr_i,
  output logic          viol_o
);
  logic [AW-1:0] prev_q;
  logic [AW-1:0] diff;
  logic          multi;

  assign diff  = addr_i ^ prev_q;
  // two or more set bits: clearing the lowest still leaves one
  assign multi = (diff & (diff - AW'(1))) != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      viol_o <= 1'b0;
    end else begin
      prev_q <= addr_i;
      viol_o <= multi && (mode_i != MODE_HOLD);
    end
  end

  a_r8_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> !viol_o);
  a_r7_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(mode_i != MODE_HOLD));
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int unsigned NLOC = 8,
  localparam int unsigned AW = $clog2(NLOC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            data_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            le_ni,
  input  logic            mr_ni,
  output logic [NLOC-1:0] q_o,
  output logic            addr_viol_o
);
  lat_mode_e mode;

  lat_mode_dec u_dec (
    .le_ni  (le_ni),
    .mr_ni  (mr_ni),
    .mode_o (mode)
  );

  lat_store #(.NLOC(NLOC)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .data_i (data_i),
    .addr_i (addr_i),
    .q_o    (q_o)
  );

  addr_watch #(.AW(AW)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .addr_i (addr_i),
    .viol_o (addr_viol_o)
  );

  a_r2_write_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_ni && !le_ni) |=> (q_o[$past(addr_i)] == $past(data_i)));
  a_r6_demux_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mr_ni && !le_ni) |=>
      (q_o == ($past({{(NLOC-1){1'b0}}, data_i}) << $past(addr_i))));
endmodule

// File: tb/tb_addr_latch.sv
module tb_addr_latch;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic       le_ni = 1'b1;
  logic       mr_ni = 1'b1;
  logic [7:0] q_o;
  logic       addr_viol_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_latch dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .addr_i(addr_i),
    .le_ni(le_ni), .mr_ni(mr_ni), .q_o(q_o), .addr_viol_o(addr_viol_o)
  );

  // {req[3:0], mr_n, le_n, d, addr[2:0], q_exp[7:0], viol_exp}
  localparam int NV = 20;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b0, 1'b1, 3'd0, 8'h01, 1'b0},
    {4'd2, 1'b1, 1'b0, 1'b1, 3'd1, 8'h03, 1'b0},
    {4'd3, 1'b1, 1'b1, 1'b0, 3'd7, 8'h03, 1'b0},
    {4'd2, 1'b1, 1'b0, 1'b1, 3'd7, 8'h83, 1'b0},
    {4'd2, 1'b1, 1'b0, 1'b1, 3'd3, 8'h8B, 1'b0},
    {4'd7, 1'b1, 1'b0, 1'b0, 3'd0, 8'h8A, 1'b1},
    {4'd2, 1'b1, 1'b0, 1'b0, 3'd1, 8'h88, 1'b0},
    {4'd3, 1'b1, 1'b1, 1'b1, 3'd2, 8'h88, 1'b0},
    {4'd4, 1'b0, 1'b0, 1'b1, 3'd2, 8'h04, 1'b0},
    {4'd4, 1'b0, 1'b0, 1'b1, 3'd6, 8'h40, 1'b0},
    {4'd7, 1'b0, 1'b0, 1'b1, 3'd1, 8'h02, 1'b1},
    {4'd4, 1'b0, 1'b0, 1'b0, 3'd1, 8'h00, 1'b0},
    {4'd9, 1'b1, 1'b1, 1'b1, 3'd5, 8'h00, 1'b0},
    {4'd4, 1'b0, 1'b0, 1'b1, 3'd5, 8'h20, 1'b0},
    {4'd9, 1'b1, 1'b1, 1'b0, 3'd0, 8'h20, 1'b0},
    {4'd2, 1'b1, 1'b0, 1'b1, 3'd4, 8'h30, 1'b0},
    {4'd5, 1'b0, 1'b1, 1'b1, 3'd7, 8'h00, 1'b1},
    {4'd8, 1'b1, 1'b1, 1'b1, 3'd3, 8'h00, 1'b0},
    {4'd2, 1'b1, 1'b0, 1'b1, 3'd3, 8'h08, 1'b0},
    {4'd7, 1'b1, 1'b0, 1'b1, 3'd5, 8'h28, 1'b1}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got q=%h viol=%b, expected q=%h viol=%b",
               req, act[8:1], act[0], exp[8:1], exp[0]);
    end
  endtask

  task automatic apply(input logic mr, input logic le, input logic d, input logic [2:0] a);
    @(negedge clk);
    mr_ni = mr; le_ni = le; data_i = d; addr_i = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running, expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {q_o, addr_viol_o}, 9'h000);
    @(negedge clk) rst_ni = 1'b1;

    // vector table: R2 write, R3 hold, R4 demux, R5 clear, R7/R8 flag, R9 exit to hold
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:9]);
      check($sformatf("R%0d vec%0d", VEC[i][18:15], i), {q_o, addr_viol_o}, VEC[i][8:0]);
    end

    // R1: asynchronous reset mid-run, no clock edge needed
    @(negedge clk) rst_ni = 1'b0;
    #2;
    check("R1 async", {q_o, addr_viol_o}, 9'h000);
    @(negedge clk) rst_ni = 1'b1;

    // R6: each address maps to its own bit (viol not compared)
    for (int k = 0; k < 8; k++) begin
      apply(1'b0, 1'b0, 1'b1, 3'(k));
      check($sformatf("R6 addr%0d", k), {q_o, 1'b0}, {8'(1) << k, 1'b0});
    end

    // R8: single-bit step outside hold raises no flag (prev addr = 7)
    apply(1'b1, 1'b0, 1'b0, 3'd6);
    check("R8 onebit", {q_o, addr_viol_o}, {8'h80, 1'b0});
    // R3: hold ignores data and a three-bit jump
    apply(1'b1, 1'b1, 1'b1, 3'd1);
    check("R3 hold", {q_o, addr_viol_o}, {8'h80, 1'b0});
    // R7: flag is a single-cycle pulse
    apply(1'b1, 1'b0, 1'b1, 3'd6);
    check("R7 jump", {q_o, addr_viol_o}, {8'hC0, 1'b1});
    apply(1'b1, 1'b1, 1'b0, 3'd6);
    check("R7 pulse end", {q_o, addr_viol_o}, {8'hC0, 1'b0});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule